// File: doc/BRIEF.md
# Synchronous Reset Sequence Generator

This block produces the chip-wide internal reset and controls the pull-down on an open-drain external reset pin. It starts a sequence on power-on, on any internal reset request (for example a clock-loss detector or a watchdog), or when the external pin is seen low while idle. It then pulls the pin low, lets it go, waits a fixed recovery window, and releases the internal reset on a clock edge. If some other device is still holding the pin low at that point, the internal reset stays on until the pin is seen high.

The pull-down phase starts once the block's own drive has come back through the pin synchronizer. This adds a latency n on top of the fixed pull-down count, so the pin is low for 128+n cycles and n depends on the synchronizer depth. A 64-cycle release window follows, which brings the counted sequence to 192 cycles. Any new internal request restarts the sequence from the beginning. Requests raise the internal reset at once, without waiting for a clock edge. When the internal reset drops, a one-cycle strobe is issued so that logic downstream can capture the reset cause.

Top module: `rst_seq_gen`

## Requirements
- R1: While por_n is low, sys_rst and pin_pd are high and done is low, with no clock edge needed.
- R2: Any bit of req that is high drives sys_rst high in the same cycle, before the next clock edge.
- R3: After a request, pin_pd stays high for 128+n cycles, where n lies between 3 and 6.
- R4: Once pin_pd falls, sys_rst stays high for 64 more cycles. It then falls on a clock edge, provided the pin is high.
- R5: done is high for exactly one cycle, which is the first cycle in which sys_rst is low again.
- R6: If the pin is still held low at the end of the 64-cycle window, sys_rst stays high. It falls within 7 cycles after the pin is released.
- R7: A request that arrives during the pull-down or release phase restarts the whole sequence. pin_pd is high again for 128+n cycles, and then the 64-cycle window follows.
- R8: If the external pin goes low while the block is idle, sys_rst rises within SYNC_STAGES+2 cycles and a full sequence follows.
- R9: If a request lands on the cycle in which the sequence would end, sys_rst does not fall, done does not pulse, and a full new sequence runs.
- R10: When idle with no source active, sys_rst, pin_pd and done all stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_in | input | 1 | Sampled level of the external reset pin (1 = high) |
| req | input | NREQ | Internal reset requests, active high |
| sys_rst | output | 1 | Internal system reset, active high |
| pin_pd | output | 1 | Pull-down enable for the open-drain reset pin |
| done | output | 1 | One-cycle strobe when sys_rst is released |

## Verification
Two events can fall in the same cycle: the final edge of the release window and a fresh internal request. The bench sets up this collision by counting exactly 64 cycles after the pull-down drops and raising a request just before the edge that would release the reset. It passes only if done stays low, sys_rst never drops, and a complete new pull-down and release sequence follows. A second collision comes from an external hold that ends near the window boundary. It is judged by the measured release length, which must fall between the hold length plus one and the hold length plus seven.

// File: rtl/rst_seq_gen.sv
module rst_seq_gen #(
  parameter int NREQ        = 2,
  parameter int PD_CYCLES   = 128,
  parameter int REL_CYCLES  = 64,
  parameter int SYNC_STAGES = 3
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            pin_in,
  input  logic [NREQ-1:0] req,
  output logic            sys_rst,
  output logic            pin_pd,
  output logic            done
);

  localparam int CMAX0 = (PD_CYCLES > REL_CYCLES) ? PD_CYCLES : REL_CYCLES;
  localparam int CMAX  = (CMAX0 > SYNC_STAGES) ? CMAX0 : SYNC_STAGES;
  localparam int CW    = $clog2(CMAX + 1);
  localparam logic [CW-1:0] ARM_END  = CW'(SYNC_STAGES);
  localparam logic [CW-1:0] PULL_END = CW'(PD_CYCLES - 1);
  localparam logic [CW-1:0] REL_END  = CW'(REL_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_PULL, S_REL} st_t;

  st_t                    st, nst;
  logic [CW-1:0]          cnt, ncnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   done_q;

  wire pin_s   = sync_q[SYNC_STAGES-1];
  wire any_req = |req;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
  end

  always_comb begin
    nst  = st;
    ncnt = cnt + CW'(1);
    if (any_req) begin
      nst  = S_ARM;
      ncnt = '0;
    end else begin
      case (st)
        S_IDLE: begin
          ncnt = '0;
          if (!pin_s) nst = S_ARM;
        end
        S_ARM: begin
          if (cnt >= ARM_END) begin
            ncnt = cnt;
            if (!pin_s) begin
              nst  = S_PULL;
              ncnt = '0;
            end
          end
        end
        S_PULL: begin
          if (cnt == PULL_END) begin
            nst  = S_REL;
            ncnt = '0;
          end
        end
        default: begin
          if (cnt == REL_END) begin
            ncnt = cnt;
            if (pin_s) nst = S_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st     <= S_ARM;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      st     <= nst;
      cnt    <= ncnt;
      done_q <= (nst == S_IDLE) && (st != S_IDLE);
    end
  end

  assign pin_pd  = (st == S_ARM) || (st == S_PULL) || !por_n;
  assign sys_rst = (st != S_IDLE) || any_req || !por_n;
  assign done    = done_q;

endmodule

// File: rtl/rst_seq_gen_chk.sv
module rst_seq_gen_chk #(
  parameter int NREQ       = 2,
  parameter int PD_CYCLES  = 128,
  parameter int REL_CYCLES = 64
) (
  input logic            clk,
  input logic            por_n,
  input logic            pin_in,
  input logic [NREQ-1:0] req,
  input logic            sys_rst,
  input logic            pin_pd,
  input logic            done
);

  logic [15:0] pd_cnt, rel_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pd_cnt  <= '0;
      rel_cnt <= '0;
    end else begin
      pd_cnt  <= pin_pd ? ((pd_cnt == 16'hffff) ? pd_cnt : pd_cnt + 16'd1) : 16'd0;
      rel_cnt <= pin_pd ? 16'd0 :
                 (sys_rst ? ((rel_cnt == 16'hffff) ? rel_cnt : rel_cnt + 16'd1) : 16'd0);
    end
  end

  a_r1_por_holds: assert property (@(posedge clk) !por_n |-> (sys_rst && pin_pd && !done));

  a_r2_req_asserts: assert property (@(posedge clk) disable iff (!por_n)
    (|req) |-> sys_rst);

  a_r3_pd_min_len: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pin_pd) |-> (pd_cnt >= 16'(PD_CYCLES)));

  a_r3_pd_inside_rst: assert property (@(posedge clk) disable iff (!por_n)
    pin_pd |-> sys_rst);

  a_r4_rel_window: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> (rel_cnt >= 16'(REL_CYCLES)));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!por_n)
    done |=> !done);

  a_r5_done_after_rst: assert property (@(posedge clk) disable iff (!por_n)
    done |-> $past(sys_rst));

  a_r10_done_only_on_fall: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> done);

endmodule

bind rst_seq_gen rst_seq_gen_chk #(
  .NREQ(NREQ), .PD_CYCLES(PD_CYCLES), .REL_CYCLES(REL_CYCLES)
) u_chk (
  .clk(clk), .por_n(por_n), .pin_in(pin_in), .req(req),
  .sys_rst(sys_rst), .pin_pd(pin_pd), .done(done)
);

// File: tb/rst_seq_gen_tb.sv
module rst_seq_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 2;
  localparam int SYNC = 3;
  localparam int PD = 128;
  localparam int REL = 64;
  localparam int NVEC = 6;
  // each row: source (0..NREQ-1 = request bit, NREQ = external pin), hold length (0 = none)
  localparam int VEC [NVEC][2] = '{'{0, 0}, '{1, 0}, '{2, 0}, '{0, 80}, '{2, 120}, '{1, 65}};

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [NREQ-1:0] req = '0;
  logic ext_low = 1'b0;
  logic sys_rst, pin_pd, done;
  wire  pin_in = ~(pin_pd | ext_low);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  rst_seq_gen #(.NREQ(NREQ), .PD_CYCLES(PD), .REL_CYCLES(REL), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .por_n(por_n), .pin_in(pin_in), .req(req),
    .sys_rst(sys_rst), .pin_pd(pin_pd), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic measure(input int hold, input string tag, output int pd_len, output int rel_len);
    int g = 0;
    pd_len = 0;
    rel_len = 0;
    while (!pin_pd && g < 10) begin @(negedge clk); g++; end
    while (pin_pd && pd_len < 1000) begin pd_len++; @(negedge clk); end
    while (sys_rst && rel_len < 2000) begin
      rel_len++;
      if (hold > 0 && rel_len == hold) ext_low = 1'b0;
      @(negedge clk);
    end
    chk({tag, " R5 done on release"}, int'(done), 1, 1);
    @(negedge clk);
    chk({tag, " R5 done one cycle"}, int'(done), 0, 0);
  endtask

  task automatic trig_req(input int b);
    @(negedge clk);
    req[b] = 1'b1;
    #1;
    chk("R2 request asserts reset at once", int'(sys_rst), 1, 1);
    @(negedge clk);
    req = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pl, rl, w;
    #1;
    chk("R1 por sys_rst", int'(sys_rst), 1, 1);
    chk("R1 por pin_pd", int'(pin_pd), 1, 1);
    chk("R1 por done", int'(done), 0, 0);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    measure(0, "por", pl, rl);
    chk("R3 por pull-down length", pl, PD + 3, PD + 6);
    chk("R4 por release window", rl, REL, REL);

    repeat (20) @(negedge clk);
    chk("R10 idle sys_rst", int'(sys_rst), 0, 0);
    chk("R10 idle pin_pd", int'(pin_pd), 0, 0);
    chk("R10 idle done", int'(done), 0, 0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][0] < NREQ) begin
        trig_req(VEC[i][0]);
        if (VEC[i][1] > 0) ext_low = 1'b1;
      end else begin
        @(negedge clk);
        ext_low = 1'b1;
        w = 0;
        while (!sys_rst && w < 20) begin @(negedge clk); w++; end
        chk("R8 external pin starts sequence", w, 1, SYNC + 2);
        if (VEC[i][1] == 0) ext_low = 1'b0;
      end
      measure(VEC[i][1], "vec", pl, rl);
      chk("R3 vec pull-down length", pl, PD + 3, PD + 6);
      if (VEC[i][1] == 0) chk("R4 vec release window", rl, REL, REL);
      else chk("R6 vec external hold", rl, VEC[i][1] + 1, VEC[i][1] + 7);
      repeat (5) @(negedge clk);
    end

    trig_req(0);
    repeat (50) @(negedge clk);
    trig_req(1);
    measure(0, "R7 pull", pl, rl);
    chk("R7 restart in pull-down", pl, PD + 3, PD + 6);
    chk("R7 restart release window", rl, REL, REL);

    trig_req(1);
    while (pin_pd) @(negedge clk);
    repeat (30) @(negedge clk);
    trig_req(0);
    measure(0, "R7 rel", pl, rl);
    chk("R7 restart in release re-pulls pin", pl, PD + 3, PD + 6);
    chk("R7 restart in release window", rl, REL, REL);

    trig_req(0);
    while (pin_pd) @(negedge clk);
    repeat (REL - 1) @(negedge clk);
    req[1] = 1'b1;
    @(negedge clk);
    chk("R9 collision no done", int'(done), 0, 0);
    req = '0;
    #1;
    chk("R9 collision keeps reset", int'(sys_rst), 1, 1);
    chk("R9 collision pulls pin", int'(pin_pd), 1, 1);
    measure(0, "R9", pl, rl);
    chk("R9 full sequence after collision", pl + 1, PD + 3, PD + 6);
    chk("R9 release after collision", rl, REL, REL);

    repeat (10) @(negedge clk);
    chk("R10 final idle", int'(sys_rst | pin_pd | done), 0, 0);
    finish_run();
  end
endmodule